// File: doc/BRIEF.md
# Mains Time-Slot Counter

This block keeps the three-bit time-slot count that a power-line modem reports to its host in the status message. With this count the host can follow when the shared half-duplex channel becomes free again. The count starts at 7, which marks the channel as unusable. When a communication ends, the count loads to 0. That value stands for the slot just before the first free one. Each pre-slot pulse after that numbers the next free slot, from 1 up to 7. When a repetition starts, the count is forced back to 7.

A ready flag is high while the count is 0. It tells the host that a data-transmit request can be accepted. The block also holds a separate snapshot of the count for status reads. The snapshot is captured in step with the pre-slot pulse, so a read always returns a settled value.

Top module: `slot_counter`

## Requirements
- R1: After reset the count is 7, the ready flag is 0 and the snapshot is 7.
- R2: A repetition-start pulse makes the count 7 on the next cycle.
- R3: A pulse on end-of-receive, end-of-transmit or end-of-repetition makes the count 0 on the next cycle, provided repetition-start is low in that cycle.
- R4: A pre-slot pulse with the count below 7, and with no event in the same cycle, raises the count by one on the next cycle.
- R5: A pre-slot pulse with the count at 7 leaves it at 7. Only an end-of-communication event brings it down.
- R6: The ready flag is 1 exactly when the count is 0, in the same cycle.
- R7: When repetition-start and an end event occur in the same cycle, the count becomes 7. Either event takes precedence over a pre-slot pulse in the same cycle.
- R8: The snapshot takes the count value on the cycle after each pre-slot pulse and holds its value in every other cycle.
- R9: With all event inputs low, the count keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_slot | input | 1 | One-cycle pulse marking a slot boundary |
| rx_done | input | 1 | End-of-receive pulse |
| tx_done | input | 1 | End-of-transmit pulse |
| rep_done | input | 1 | End-of-repetition pulse |
| rep_begin | input | 1 | Repetition-start pulse |
| slot_cnt | output | 3 | Live time-slot count (7 means unusable) |
| data_ready | output | 1 | High while the count is 0 |
| slot_snap | output | 3 | Count captured after the last pre-slot pulse |

## Verification
On every cycle, the assertions check the count's next value after a repetition start, an end event or a pre-slot pulse. They also check that the count stays at 7 and that it holds when no input is active. The snapshot's capture-or-hold rule is checked the same way. The bench scenarios are needed for what only a sequence can show. These are the full count from 0 to 7 followed by extra pulses, the ready flag following the count, each of the three end sources, and the two collision cases in the priority rule.

// File: rtl/slot_counter.sv
module slot_counter #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pre_slot,
  input  logic          rx_done,
  input  logic          tx_done,
  input  logic          rep_done,
  input  logic          rep_begin,
  output logic [CW-1:0] slot_cnt,
  output logic          data_ready,
  output logic [CW-1:0] slot_snap
);
  localparam logic [CW-1:0] TOP  = {CW{1'b1}};
  localparam logic [CW-1:0] ZERO = '0;

  logic comm_end;
  logic pre_q;

  assign comm_end   = rx_done | tx_done | rep_done;
  assign data_ready = (slot_cnt == ZERO);

  always_ff @(posedge clk) begin
    if (!rst_n)              slot_cnt <= TOP;
    else if (rep_begin)      slot_cnt <= TOP;
    else if (comm_end)       slot_cnt <= ZERO;
    else if (pre_slot && slot_cnt != TOP)
                             slot_cnt <= slot_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q     <= 1'b0;
      slot_snap <= TOP;
    end else begin
      pre_q <= pre_slot;
      if (pre_q) slot_snap <= slot_cnt;
    end
  end

  // R2
  rep_forces_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rep_begin |=> slot_cnt == TOP);
  // R3
  end_loads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (comm_end && !rep_begin) |=> slot_cnt == ZERO);
  // R4
  pre_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_slot && !comm_end && !rep_begin && slot_cnt != TOP)
      |=> slot_cnt == CW'($past(slot_cnt) + 1'b1));
  // R5
  top_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!comm_end && slot_cnt == TOP) |=> slot_cnt == TOP);
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_slot && !comm_end && !rep_begin) |=> $stable(slot_cnt));
  // R8
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q |=> slot_snap == $past(slot_cnt));
  // R8
  snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_q |=> $stable(slot_snap));
endmodule

// File: tb/slot_counter_test.sv
module slot_counter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pre_slot = 1'b0, rx_done = 1'b0, tx_done = 1'b0, rep_done = 1'b0, rep_begin = 1'b0;
  logic [2:0] slot_cnt, slot_snap;
  logic data_ready;

  always #4 clk = ~clk;

  slot_counter uut (
    .clk(clk), .rst_n(rst_n), .pre_slot(pre_slot), .rx_done(rx_done),
    .tx_done(tx_done), .rep_done(rep_done), .rep_begin(rep_begin),
    .slot_cnt(slot_cnt), .data_ready(data_ready), .slot_snap(slot_snap)
  );

  typedef struct {
    logic [2:0] cnt;
    logic       rdy;
    logic [2:0] snap;
    string      tag;
  } exp_t;

  exp_t q[$];
  int total = 0;
  int failed = 0;
  logic [2:0] m_cnt = 3'd7, m_snap = 3'd7;
  logic m_preq = 1'b0;
  bit done = 1'b0;

  task automatic step(input logic p, input logic rx, input logic tx,
                      input logic rp, input logic rs, input string tag);
    exp_t e;
    logic [2:0] nc;
    @(negedge clk);
    pre_slot = p; rx_done = rx; tx_done = tx; rep_done = rp; rep_begin = rs;
    if (rs)                    nc = 3'd7;
    else if (rx | tx | rp)     nc = 3'd0;
    else if (p && m_cnt != 7)  nc = m_cnt + 3'd1;
    else                       nc = m_cnt;
    if (m_preq) m_snap = m_cnt;
    m_preq = p;
    m_cnt  = nc;
    e.cnt = m_cnt; e.rdy = (m_cnt == 3'd0); e.snap = m_snap; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      failed++;
      $display("FAIL %s: got %0d, expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk({e.tag, " count"}, int'(slot_cnt), int'(e.cnt));
      chk({"R6 ready (", e.tag, ")"}, int'(data_ready), int'(e.rdy));
      chk({"R8 snapshot (", e.tag, ")"}, int'(slot_snap), int'(e.snap));
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset count", int'(slot_cnt), 7);
    chk("R1 reset ready", int'(data_ready), 0);
    chk("R1 reset snapshot", int'(slot_snap), 7);
    rst_n = 1'b1;
    step(1, 0, 0, 0, 0, "R5 pulse at 7 after reset");
    step(0, 0, 0, 0, 0, "R9 idle");
    step(0, 0, 0, 1, 0, "R3 end of repetition");
    step(0, 0, 0, 0, 0, "R9 idle at 0");
    for (int i = 0; i < 7; i++) step(1, 0, 0, 0, 0, "R4 count up");
    step(1, 0, 0, 0, 0, "R5 stays at 7");
    step(1, 0, 0, 0, 0, "R5 stays at 7");
    step(0, 0, 0, 0, 0, "R9 idle");
    step(0, 1, 0, 0, 0, "R3 end of receive");
    step(1, 0, 0, 0, 0, "R4 to 1");
    step(0, 0, 0, 0, 0, "R8 snap after pulse");
    step(0, 0, 0, 0, 0, "R8 snap holds");
    step(1, 0, 0, 0, 0, "R4 to 2");
    step(0, 0, 0, 0, 0, "R9 idle");
    step(0, 0, 0, 0, 1, "R2 repetition start");
    step(0, 0, 1, 0, 0, "R3 end of transmit");
    step(1, 0, 0, 0, 0, "R4 to 1");
    step(1, 1, 0, 0, 0, "R7 end beats pulse");
    step(0, 0, 0, 0, 0, "R9 idle");
    step(0, 1, 0, 0, 1, "R7 repetition beats end");
    step(1, 0, 0, 1, 0, "R7 end beats pulse");
    step(1, 0, 1, 0, 1, "R7 repetition beats both");
    step(0, 0, 0, 0, 0, "R9 idle");
    step(0, 0, 0, 0, 0, "R9 idle");
    while (q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule